// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A byte is offered with a valid/ready handshake. When the block accepts it, the block sends a start bit, then 5 to 8 data bits least significant bit first, then an optional parity bit, then one, one-and-a-half or two stop bits. Bit timing comes from an external one-cycle tick that runs at 16 times the bit rate.

An 8-bit line-control input sets the frame format. The block samples this input when it accepts a character, so the surrounding logic may rewrite it while a frame is on the wire. The break bit is the one exception: it takes effect at once. While break is set, the line is held low, and the frame timing keeps running underneath.

Top module: `sertx_top`

## Requirements
- R1: After reset, `tx_line` is 1, `tx_busy` is 0 and `in_ready` is 1.
- R2: A frame is a start bit of 0, then the data bits least significant bit first, then the stop bits at 1. Each bit lasts `TICKS_PER_BIT` (16) baud ticks. Between frames the line rests at 1.
- R3: `line_ctrl[1:0]` selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above that count are not sent.
- R4: `line_ctrl[2]`=0 sends one stop bit. `line_ctrl[2]`=1 sends two stop bits, or a full stop bit followed by a half bit of 8 ticks when the character has 5 data bits.
- R5: With `line_ctrl[3]`=0 no parity bit is sent, whatever `line_ctrl[5:4]` hold.
- R6: With `line_ctrl[3]`=1 and `line_ctrl[5]`=0, a parity bit follows the data. `line_ctrl[4]`=0 makes the count of ones in data plus parity odd, and `line_ctrl[4]`=1 makes it even.
- R7: With `line_ctrl[3]`=1 and `line_ctrl[5]`=1, the parity bit is forced: `line_ctrl[4]`=0 sends 1 and `line_ctrl[4]`=1 sends 0.
- R8: While `line_ctrl[6]`=1, `tx_line` is 0 in the same cycle, both when idle and during a frame. The frame keeps its timing underneath, and the line carries the frame again once the bit clears.
- R9: The block samples `line_ctrl[5:0]` in the accepting cycle. Later changes to those bits do not alter the frame in progress. `line_ctrl[7]` has no effect.
- R10: `in_ready` equals not `tx_busy`. A byte is accepted on a cycle with `in_valid` and `in_ready` both high. `tx_busy` is 1 from the next cycle until the last stop tick has elapsed. `in_valid` is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can accept a byte |
| in_data | input | 8 | Byte to send |
| line_ctrl | input | 8 | Frame format and break control |
| tx_line | output | 1 | Serial output |
| tx_busy | output | 1 | A frame is in progress |

## Verification
The bench builds the block with its default of 16 ticks per bit and pulses the baud tick on every other clock. This makes the 8-tick half stop bit a distinct, measurable length next to the full 16-tick bit. A table walks every word length, every stop mode and every parity mode, including the 1.5-stop case and a control byte with the unused top bit set. Each frame is captured one tick at a time and compared with a waveform built from the control byte. Directed runs cover the following:
- break raised inside a frame and then cleared;
- a rewrite of every format bit just after acceptance;
- `in_valid` held high through a whole frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP1,
        PH_STOP2
    } phase_e;

    typedef struct packed {
        logic       par_force;
        logic       par_even;
        logic       par_on;
        logic       two_stop;
        logic [1:0] len_code;
    } frame_cfg_t;

    function automatic frame_cfg_t decode_cfg(input logic [7:0] ctrl);
        frame_cfg_t c;
        c.len_code  = ctrl[1:0];
        c.two_stop  = ctrl[2];
        c.par_on    = ctrl[3];
        c.par_even  = ctrl[4];
        c.par_force = ctrl[5];
        return c;
    endfunction

    function automatic logic [3:0] data_bits(input logic [1:0] len_code);
        return 4'd5 + {2'b00, len_code};
    endfunction

    function automatic logic parity_of(input frame_cfg_t c, input logic [7:0] d);
        logic [7:0] mask;
        logic       x;
        mask = 8'hFF >> (3 - c.len_code);
        x    = ^(d & mask);
        if (c.par_force) return ~c.par_even;
        return c.par_even ? x : ~x;
    endfunction

endpackage

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic active,
    input  logic half,
    input  logic baud_tick,
    output logic bit_done
);
    localparam int CW = $clog2(TICKS_PER_BIT);
    localparam logic [CW:0] FULL_LAST = (CW+1)'(TICKS_PER_BIT - 1);
    localparam logic [CW:0] HALF_LAST = (CW+1)'(TICKS_PER_BIT / 2 - 1);

    logic [CW:0] cnt;
    logic [CW:0] last;

    assign last     = half ? HALF_LAST : FULL_LAST;
    assign bit_done = active && baud_tick && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || restart || bit_done) begin
            cnt <= '0;
        end else if (active && baud_tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: the tick count never passes the length of a full bit
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL_LAST);

    // R4: a half-length bit never counts beyond its own length
    p_half_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (active && half) |-> cnt <= HALF_LAST);

endmodule

// File: rtl/sertx_frame_fsm.sv
module sertx_frame_fsm
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  logic [7:0] in_data,
    input  logic [7:0] line_ctrl,
    input  logic       bit_done,
    output logic       frame_bit,
    output logic       busy,
    output logic       half
);
    phase_e     phase;
    frame_cfg_t cfg_q;
    logic [7:0] shreg;
    logic [2:0] idx;
    logic       par_q;
    frame_cfg_t cfg_in;
    logic [2:0] last_idx;

    assign cfg_in   = decode_cfg(line_ctrl);
    assign last_idx = 3'(data_bits(cfg_q.len_code) - 4'd1);
    assign busy     = (phase != PH_IDLE);
    assign half     = (phase == PH_STOP2) && (cfg_q.len_code == 2'b00);

    always_comb begin
        unique case (phase)
            PH_START:  frame_bit = 1'b0;
            PH_DATA:   frame_bit = shreg[0];
            PH_PARITY: frame_bit = par_q;
            default:   frame_bit = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cfg_q <= '0;
            shreg <= '0;
            idx   <= '0;
            par_q <= 1'b0;
        end else if (phase == PH_IDLE) begin
            if (accept) begin
                phase <= PH_START;
                cfg_q <= cfg_in;
                shreg <= in_data;
                idx   <= '0;
                par_q <= parity_of(cfg_in, in_data);
            end
        end else if (bit_done) begin
            unique case (phase)
                PH_START: phase <= PH_DATA;
                PH_DATA: begin
                    if (idx == last_idx) begin
                        phase <= cfg_q.par_on ? PH_PARITY : PH_STOP1;
                    end else begin
                        idx   <= idx + 1'b1;
                        shreg <= shreg >> 1;
                    end
                end
                PH_PARITY: phase <= PH_STOP1;
                PH_STOP1:  phase <= cfg_q.two_stop ? PH_STOP2 : PH_IDLE;
                default:   phase <= PH_IDLE;
            endcase
        end
    end

    // R2: the first bit after acceptance is a start bit of 0
    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> frame_bit == 1'b0);

    // R9: the latched format holds still for the whole frame
    p_cfg_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg_q));

    // R5: the parity phase is reached only with parity enabled
    p_parity_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PARITY) |-> cfg_q.par_on);

    // R4: the second stop phase is reached only when two stops are selected
    p_stop2_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STOP2) |-> cfg_q.two_stop);

    // R3: the data bit index stays within the selected length
    p_idx_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA) |-> idx <= last_idx);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic [7:0] line_ctrl,
    output logic       tx_line,
    output logic       tx_busy
);
    logic accept;
    logic bit_done;
    logic frame_bit;
    logic half;
    logic brk;

    assign brk      = line_ctrl[6];
    assign in_ready = ~tx_busy;
    assign accept   = in_valid && in_ready;
    assign tx_line  = brk ? 1'b0 : frame_bit;

    sertx_frame_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .in_data   (in_data),
        .line_ctrl (line_ctrl),
        .bit_done  (bit_done),
        .frame_bit (frame_bit),
        .busy      (tx_busy),
        .half      (half)
    );

    sertx_bit_timer #(
        .TICKS_PER_BIT (TICKS_PER_BIT)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .restart   (accept),
        .active    (tx_busy),
        .half      (half),
        .baud_tick (baud_tick),
        .bit_done  (bit_done)
    );

    // R10: an accepted byte makes the block busy on the next cycle
    p_accept_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> tx_busy);

    // R2: an idle line without break rests high
    p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
        (!tx_busy && !line_ctrl[6]) |-> tx_line);

    // R10: busy ends only on a baud tick
    p_busy_end_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_busy) |-> $past(baud_tick));

endmodule

// File: tb/sertx_top_tb.sv
module sertx_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic [7:0] line_ctrl = 8'h00;
    logic       tx_line;
    logic       tx_busy;

    int checks = 0;
    int failures = 0;

    logic [0:255] exp_bits;
    logic [0:255] got_bits;
    int           exp_len;
    int           got_len;

    always #5 clk = ~clk;

    sertx_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .baud_tick (baud_tick),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .line_ctrl (line_ctrl),
        .tx_line   (tx_line),
        .tx_busy   (tx_busy)
    );

    // {line_ctrl, data}
    localparam logic [15:0] VEC [12] = '{
        16'h03A5,   // R3 8 bits, R4 one stop
        16'h0015,   // R3 5 bits
        16'h012A,   // R3 6 bits
        16'h0255,   // R3 7 bits
        16'h0413,   // R4 5 bits, 1.5 stops
        16'h053F,   // R4 6 bits, 2 stops
        16'h0BA6,   // R6 odd
        16'h1BA6,   // R6 even
        16'h2B00,   // R7 forced 1
        16'h3BFF,   // R7 forced 0
        16'h33C3,   // R5 parity off with bits 5:4 set
        16'h8E0F    // R9 top bit set, 7 bits odd, 2 stops
    };

    task automatic check(input string req, input logic ok, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic push_bit(input logic b, input int n);
        for (int i = 0; i < n; i++) begin
            exp_bits[exp_len] = b;
            exp_len++;
        end
    endtask

    task automatic build_expected(input logic [7:0] d, input logic [7:0] c);
        int  n;
        logic x;
        n = 5 + int'(c[1:0]);
        exp_len = 0;
        x = 1'b0;
        push_bit(1'b0, 16);
        for (int i = 0; i < n; i++) begin
            push_bit(d[i], 16);
            x = x ^ d[i];
        end
        if (c[3]) begin
            if (c[5]) push_bit(~c[4], 16);
            else      push_bit(c[4] ? x : ~x, 16);
        end
        push_bit(1'b1, 16);
        if (c[2]) push_bit(1'b1, (n == 5) ? 8 : 16);
    endtask

    task automatic run_frame(input string req, input logic [7:0] d,
                             input logic [7:0] c0, input logic [7:0] c1,
                             input int bfrom, input int bto, input logic hold);
        logic tog;
        int   mism;
        logic saw_ready;
        build_expected(d, c0);
        for (int k = bfrom; k < bto; k++) exp_bits[k] = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_data = d; line_ctrl = c0; baud_tick = 1'b0;
        @(negedge clk);
        if (!hold) in_valid = 1'b0;
        in_data = ~d;
        check(req, tx_busy == 1'b1, "busy after accept", tx_busy, 1);
        got_len = 0; tog = 1'b0; saw_ready = 1'b0;
        for (int guard = 0; guard < 1000; guard++) begin
            if (guard > 0) @(negedge clk);
            if (!tx_busy) break;
            if (in_ready) saw_ready = 1'b1;
            tog = ~tog;
            baud_tick = tog;
            line_ctrl = (got_len >= bfrom && got_len < bto) ? (c1 | 8'h40) : c1;
            #1;
            if (baud_tick) begin
                if (got_len < 256) got_bits[got_len] = tx_line;
                got_len++;
            end
        end
        baud_tick = 1'b0;
        in_valid = 1'b0;
        check(req, got_len == exp_len, "frame length in ticks", got_len, exp_len);
        mism = -1;
        for (int k = 0; k < exp_len && k < got_len; k++)
            if (mism < 0 && got_bits[k] !== exp_bits[k]) mism = k;
        check(req, mism < 0, "line value at first mismatching tick",
              (mism < 0) ? 0 : int'(got_bits[mism]),
              (mism < 0) ? 0 : int'(exp_bits[mism]));
        if (hold) begin
            check("R10", saw_ready == 1'b0, "ready low during frame", saw_ready, 0);
            @(negedge clk);
            check("R10", tx_busy == 1'b0 && tx_line == 1'b1,
                  "no frame from valid held while busy", {tx_busy, tx_line}, 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1", tx_line == 1'b1, "line after reset", tx_line, 1);
        check("R1", tx_busy == 1'b0, "busy after reset", tx_busy, 0);
        check("R1", in_ready == 1'b1, "ready after reset", in_ready, 1);

        // table walk: R2 R3 R4 R5 R6 R7 R9
        for (int v = 0; v < 12; v++)
            run_frame("R2", VEC[v][7:0], VEC[v][15:8], VEC[v][15:8], -1, -1, 1'b0);

        // R8 break while idle
        @(negedge clk); line_ctrl = 8'h40; #1;
        check("R8", tx_line == 1'b0, "break idle line", tx_line, 0);
        check("R8", tx_busy == 1'b0, "break idle busy", tx_busy, 0);
        @(negedge clk); line_ctrl = 8'h00; #1;
        check("R8", tx_line == 1'b1, "line after break clear", tx_line, 1);

        // R8 break inside a frame, then cleared
        run_frame("R8", 8'hA5, 8'h1B, 8'h1B, 20, 40, 1'b0);

        // R9 format rewritten after acceptance
        run_frame("R9", 8'h3C, 8'h00, 8'h3F, -1, -1, 1'b0);

        // R10 valid held through a frame
        run_frame("R10", 8'h5A, 8'h0B, 8'h0B, -1, -1, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule